// File: doc/BRIEF.md
# Start-Code Scanner with Emulation-Byte Removal

This block is an in-line byte filter for a compressed video bitstream. Bytes arrive on a valid/ready byte stream and leave on a second one. While a run is active, a search stage looks at every window of three consecutive input bytes for a programmable start code. It can end the run on a match, or after a programmed number of input bytes. The start-code bytes are not forwarded. The bytes before them leave in their original order.

A second stage sits behind the search stage. When enabled, it removes emulation-prevention bytes: a 0x03 that follows two or more 0x00 bytes. Either stage can be bypassed on its own. A forward enable can also discard all output of a run while the input is still consumed.

At the end of every run the block reports why it stopped and how many input bytes it took. A reserved stop mode is refused without consuming anything.

Top module: `startcode_filter`

## Requirements
- R1: After a synchronous reset, busy, done, s_ready and m_valid are 0, stop_cause is 0 and consumed is 0.
- R2: With search enabled, the run stops when three consecutively consumed bytes equal cfg_code[7:0], cfg_code[15:8] and cfg_code[23:16], in that arrival order. stop_cause becomes 1 (code found) and none of the three bytes is forwarded. Earlier bytes are forwarded in order. This applies in both stop modes.
- R3: Every three-byte window is tested, so a partial match that fails still lets a later overlapping window match. For example, 00 00 00 01 against the code 00 00 01 forwards one 00.
- R4: In stop mode 1 (cfg_mode = 01), the run stops after exactly cfg_len consumed bytes with stop_cause 2, and every retained byte is flushed out. A cfg_len of 0 ends the run at once with nothing consumed.
- R5: With search disabled, every consumed byte is forwarded unchanged, and any start-code pattern in the data passes through.
- R6: With removal enabled, a 0x03 seen after two or more 0x00 bytes is dropped and the zero count restarts from 0. With removal disabled, such bytes pass unchanged.
- R7: With the forward enable at 0 for a run, m_valid stays 0 while bytes are still consumed and the count still advances.
- R8: A start with cfg_mode 10 or 11 consumes nothing, leaves busy at 0 and gives a done pulse with stop_cause 3.
- R9: Each run, including a refused one, produces exactly one single-cycle done pulse. At that pulse busy is 0 and consumed equals the number of input bytes accepted in the run.
- R10: Under output back-pressure no byte is lost, duplicated or reordered, and m_data holds steady while m_valid is high and m_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start a run; taken only while busy is 0 |
| cfg_mode | input | 2 | Stop mode: 00 start code, 01 byte count, 10/11 reserved |
| cfg_len | input | LEN_W | Byte count limit for mode 01 |
| cfg_code | input | 8*CODE_LEN | Start code; bits [7:0] are matched first |
| cfg_search_en | input | 1 | Enable the start-code search stage |
| cfg_epr_en | input | 1 | Enable emulation-prevention byte removal |
| cfg_fwd_en | input | 1 | Forward data downstream during the run |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_ready | input | 1 | Downstream ready |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| stop_cause | output | 2 | 0 none, 1 code found, 2 count reached, 3 reserved mode |
| consumed | output | LEN_W | Input bytes accepted in the current or last run |

## Verification
The bench builds the block with LEN_W = 8 and CODE_LEN = 3. The narrow counter puts a full-scale count run of 255 bytes within a short simulation, so the wrap-free limit of the count stop is exercised. The three-byte code width is the one the start-code and overlap cases are written for. Back-pressure is applied in several runs so that the flush of held bytes and the output hold are both reached while the output is stalled.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] EPB_VAL = 8'h03;

  typedef enum logic [1:0] {
    MODE_CODE = 2'd0,
    MODE_LEN  = 2'd1,
    MODE_RSV2 = 2'd2,
    MODE_RSV3 = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_CODE = 2'd1,
    CAUSE_LEN  = 2'd2,
    CAUSE_BAD  = 2'd3
  } stop_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } scan_state_e;
endpackage

// File: rtl/sc_scan_stage.sv
module sc_scan_stage
  import sc_pkg::*;
#(
  parameter int LEN_W    = 28,
  parameter int CODE_LEN = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [1:0]                   mode,
  input  logic [LEN_W-1:0]             len,
  input  logic [CODE_LEN*BYTE_W-1:0]   code,
  input  logic                         search_en,
  input  logic                         in_valid,
  input  logic [BYTE_W-1:0]            in_data,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [BYTE_W-1:0]            out_data,
  input  logic                         out_ready,
  output logic                         busy,
  output logic                         done,
  output logic [1:0]                   cause,
  output logic [LEN_W-1:0]             consumed
);
  localparam int HOLD = CODE_LEN - 1;
  localparam int HC_W = (CODE_LEN > 2) ? $clog2(CODE_LEN) : 1;

  scan_state_e                 st;
  scan_mode_e                  mode_q;
  stop_cause_e                 cause_q;
  logic [BYTE_W-1:0]           hold_q [HOLD];
  logic [HC_W-1:0]             hcnt;
  logic [LEN_W-1:0]            count, len_q, cnt_nx;
  logic [CODE_LEN*BYTE_W-1:0]  code_q;
  logic                        search_q;
  logic                        ov, done_q;
  logic [BYTE_W-1:0]           od;
  logic [CODE_LEN-1:0]         eq;
  logic                        adv, take, full, code_hit, len_hit;

  // window comparators: held bytes against the leading code bytes,
  // the arriving byte against the last one
  genvar g;
  for (g = 0; g < HOLD; g++) begin : g_eq
    assign eq[g] = (hold_q[g] == code_q[g*BYTE_W +: BYTE_W]);
  end
  assign eq[HOLD] = (in_data == code_q[HOLD*BYTE_W +: BYTE_W]);

  assign adv      = !ov || out_ready;
  assign in_ready = (st == ST_RUN) && adv;
  assign take     = in_valid && in_ready;
  assign full     = (hcnt == HC_W'(HOLD));
  assign code_hit = search_q && full && (&eq);
  assign cnt_nx   = count + LEN_W'(1);
  assign len_hit  = (mode_q == MODE_LEN) && (cnt_nx == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= MODE_CODE;
      cause_q  <= CAUSE_NONE;
      hcnt     <= '0;
      count    <= '0;
      len_q    <= '0;
      code_q   <= '0;
      search_q <= 1'b0;
      ov       <= 1'b0;
      od       <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (adv) ov <= 1'b0;
          if (start) begin
            mode_q   <= scan_mode_e'(mode);
            len_q    <= len;
            code_q   <= code;
            search_q <= search_en;
            count    <= '0;
            hcnt     <= '0;
            if (mode[1]) begin
              done_q  <= 1'b1;
              cause_q <= CAUSE_BAD;
            end else if ((mode == 2'(MODE_LEN)) && (len == '0)) begin
              done_q  <= 1'b1;
              cause_q <= CAUSE_LEN;
            end else begin
              cause_q <= CAUSE_NONE;
              st      <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (take) begin
            count <= cnt_nx;
            if (code_hit) begin
              ov      <= 1'b0;
              hcnt    <= '0;
              done_q  <= 1'b1;
              cause_q <= CAUSE_CODE;
              st      <= ST_IDLE;
            end else begin
              if (!search_q) begin
                ov <= 1'b1;
                od <= in_data;
              end else if (full) begin
                ov <= 1'b1;
                od <= hold_q[0];
                for (int j = 0; j < HOLD - 1; j++) hold_q[j] <= hold_q[j+1];
                hold_q[HOLD-1] <= in_data;
              end else begin
                ov <= 1'b0;
                for (int j = 0; j < HOLD; j++)
                  if (hcnt == HC_W'(j)) hold_q[j] <= in_data;
                hcnt <= hcnt + HC_W'(1);
              end
              if (len_hit) begin
                if (search_q) begin
                  st <= ST_FLUSH;
                end else begin
                  done_q  <= 1'b1;
                  cause_q <= CAUSE_LEN;
                  st      <= ST_IDLE;
                end
              end
            end
          end else if (adv) begin
            ov <= 1'b0;
          end
        end
        ST_FLUSH: begin
          if (adv) begin
            ov <= 1'b1;
            od <= hold_q[0];
            for (int j = 0; j < HOLD - 1; j++) hold_q[j] <= hold_q[j+1];
            hcnt <= hcnt - HC_W'(1);
            if (hcnt == HC_W'(1)) begin
              done_q  <= 1'b1;
              cause_q <= CAUSE_LEN;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = ov;
  assign out_data  = od;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign cause     = cause_q;
  assign consumed  = count;
endmodule

// File: rtl/sc_epr_stage.sv
module sc_epr_stage
  import sc_pkg::*;
#(
  parameter int RUN_LIM = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              epr_en,
  input  logic              fwd_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int ZR_W = $clog2(RUN_LIM + 1);

  logic              epr_q, fwd_q, ov, take, is_epb;
  logic [BYTE_W-1:0] od;
  logic [ZR_W-1:0]   zrun;

  assign in_ready = !ov || out_ready;
  assign take     = in_valid && in_ready;
  assign is_epb   = epr_q && (zrun == ZR_W'(RUN_LIM)) && (in_data == EPB_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      epr_q <= 1'b0;
      fwd_q <= 1'b0;
      ov    <= 1'b0;
      od    <= '0;
      zrun  <= '0;
    end else begin
      if (in_ready) begin
        ov <= take && !is_epb && fwd_q;
        od <= in_data;
      end
      if (take) begin
        if (is_epb || (in_data != '0)) zrun <= '0;
        else if (zrun != ZR_W'(RUN_LIM)) zrun <= zrun + ZR_W'(1);
      end
      if (clr) begin
        epr_q <= epr_en;
        fwd_q <= fwd_en;
        zrun  <= '0;
      end
    end
  end

  assign out_valid = ov;
  assign out_data  = od;
endmodule

// File: rtl/startcode_filter.sv
module startcode_filter
  import sc_pkg::*;
#(
  parameter int LEN_W    = 28,
  parameter int CODE_LEN = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_start,
  input  logic [1:0]                 cfg_mode,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic [CODE_LEN*8-1:0]      cfg_code,
  input  logic                       cfg_search_en,
  input  logic                       cfg_epr_en,
  input  logic                       cfg_fwd_en,
  input  logic                       s_valid,
  input  logic [7:0]                 s_data,
  output logic                       s_ready,
  output logic                       m_valid,
  output logic [7:0]                 m_data,
  input  logic                       m_ready,
  output logic                       busy,
  output logic                       done,
  output logic [1:0]                 stop_cause,
  output logic [LEN_W-1:0]           consumed
);
  logic              mid_valid, mid_ready, start_acc;
  logic [BYTE_W-1:0] mid_data;

  assign start_acc = cfg_start && !busy;

  sc_scan_stage #(.LEN_W(LEN_W), .CODE_LEN(CODE_LEN)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .start     (cfg_start),
    .mode      (cfg_mode),
    .len       (cfg_len),
    .code      (cfg_code),
    .search_en (cfg_search_en),
    .in_valid  (s_valid),
    .in_data   (s_data),
    .in_ready  (s_ready),
    .out_valid (mid_valid),
    .out_data  (mid_data),
    .out_ready (mid_ready),
    .busy      (busy),
    .done      (done),
    .cause     (stop_cause),
    .consumed  (consumed)
  );

  sc_epr_stage #(.RUN_LIM(2)) u_epr (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_acc),
    .epr_en    (cfg_epr_en),
    .fwd_en    (cfg_fwd_en),
    .in_valid  (mid_valid),
    .in_data   (mid_data),
    .in_ready  (mid_ready),
    .out_valid (m_valid),
    .out_data  (m_data),
    .out_ready (m_ready)
  );
endmodule

// File: rtl/startcode_filter_chk.sv
module startcode_filter_chk #(
  parameter int LEN_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             busy,
  input logic             done,
  input logic [1:0]       stop_cause,
  input logic [LEN_W-1:0] consumed
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R10

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !s_ready); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9

  AST_BAD_NO_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (done && (stop_cause == 2'd3)) |-> (consumed == '0)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && s_valid && s_ready) |=> (consumed == LEN_W'($past(consumed) + 1'b1))); // R9
endmodule

bind startcode_filter startcode_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .busy       (busy),
  .done       (done),
  .stop_cause (stop_cause),
  .consumed   (consumed)
);

// File: tb/startcode_filter_test.sv
module startcode_filter_test;
  localparam int LW = 8;
  localparam int K  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_start = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [LW-1:0] cfg_len = '0;
  logic [K*8-1:0] cfg_code = '0;
  logic          cfg_search_en = 1'b0, cfg_epr_en = 1'b0, cfg_fwd_en = 1'b0;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_ready;
  logic          m_valid;
  logic [7:0]    m_data;
  logic          m_ready = 1'b1;
  logic          busy, done;
  logic [1:0]    stop_cause;
  logic [LW-1:0] consumed;

  startcode_filter #(.LEN_W(LW), .CODE_LEN(K)) uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_len(cfg_len), .cfg_code(cfg_code), .cfg_search_en(cfg_search_en),
    .cfg_epr_en(cfg_epr_en), .cfg_fwd_en(cfg_fwd_en),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .busy(busy), .done(done), .stop_cause(stop_cause), .consumed(consumed)
  );

  always #5 clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  int          done_cnt = 0;
  int          cyc = 0;
  bit          bp_on = 0;
  bit          busy_seen = 0;
  string       cur_tag = "R1";
  logic [7:0]  stim[$];
  logic [7:0]  exp_q[$];
  logic [1:0]  got_cause = '0;
  logic [LW-1:0] got_cons = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: sets m_ready for the coming edge, then scores the transfer
  always @(negedge clk) begin
    logic [7:0] e;
    cyc++;
    m_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    if (!rst) begin
      if (busy) busy_seen = 1;
      if (done) begin
        done_cnt++;
        got_cause = stop_cause;
        got_cons  = consumed;
      end
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, cur_tag, "unexpected output byte", m_data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(m_data == e, cur_tag, "output byte", m_data, e);
        end
      end
    end
  end

  // reference model of the requirements; fills the scoreboard
  task automatic model(input logic [1:0] mode, input int len, input logic [23:0] code,
                       input bit s_en, input bit e_en, input bit f_en,
                       output int ecause, output int econs);
    logic [7:0] pend[$];
    logic [7:0] mid[$];
    int z;
    ecause = 0;
    econs  = 0;
    if (mode >= 2) begin
      ecause = 3;
    end else if (mode == 1 && len == 0) begin
      ecause = 2;
    end else begin
      foreach (stim[i]) begin
        econs++;
        if (s_en) begin
          pend.push_back(stim[i]);
          if (pend.size() == 3) begin
            if (pend[0] == code[7:0] && pend[1] == code[15:8] && pend[2] == code[23:16]) begin
              ecause = 1;
              pend.delete();
              break;
            end
            mid.push_back(pend.pop_front());
          end
        end else begin
          mid.push_back(stim[i]);
        end
        if (mode == 1 && econs == len) begin
          ecause = 2;
          while (pend.size() > 0) mid.push_back(pend.pop_front());
          break;
        end
      end
    end
    z = 0;
    foreach (mid[i]) begin
      if (e_en && z >= 2 && mid[i] == 8'h03) begin
        z = 0;
        continue;
      end
      if (f_en) exp_q.push_back(mid[i]);
      z = (mid[i] == 8'h00) ? ((z < 2) ? z + 1 : 2) : 0;
    end
  endtask

  task automatic run_case(input string tag, input logic [1:0] mode, input int len,
                          input logic [23:0] code, input bit s_en, input bit e_en,
                          input bit f_en, input bit bp);
    int ecause, econs, d0, i, steps, w;
    model(mode, len, code, s_en, e_en, f_en, ecause, econs);
    cur_tag   = tag;
    bp_on     = bp;
    busy_seen = 0;
    d0        = done_cnt;
    @(negedge clk);
    cfg_mode      = mode;
    cfg_len       = LW'(len);
    cfg_code      = code;
    cfg_search_en = s_en;
    cfg_epr_en    = e_en;
    cfg_fwd_en    = f_en;
    cfg_start     = 1'b1;
    i = 0;
    steps = 0;
    forever begin
      @(negedge clk);
      cfg_start = 1'b0;
      if (i < stim.size()) begin
        s_valid = 1'b1;
        s_data  = stim[i];
      end else begin
        s_valid = 1'b0;
      end
      #2;
      if (!busy || steps > 3000) begin
        s_valid = 1'b0;
        break;
      end
      if (s_valid && s_ready) i++;
      steps++;
    end
    w = 0;
    while (done_cnt == d0 && w < 100) begin
      @(negedge clk);
      w++;
    end
    repeat (12) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
    chk(got_cause == 2'(ecause), tag, "stop cause", got_cause, ecause);
    chk(got_cons == LW'(econs), "R9", "consumed count", got_cons, econs);
    chk(exp_q.size() == 0, tag, "missing output bytes", exp_q.size(), 0);
    if (mode >= 2) chk(!busy_seen, "R8", "busy during refused run", busy_seen, 0);
    exp_q.delete();
    stim.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(m_valid == 0, "R1", "m_valid", m_valid, 0);
    chk(s_ready == 0, "R1", "s_ready", s_ready, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(stop_cause == 0 && consumed == 0, "R1", "cause/count", {stop_cause, consumed}, 0);

    // R2: code 00 00 01, stops on it
    stim = '{8'h11, 8'h22, 8'h00, 8'h00, 8'h01, 8'h55, 8'h66};
    run_case("R2", 2'd0, 0, 24'h010000, 1, 0, 1, 0);

    // R3: overlapping zeros before the code
    stim = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h77};
    run_case("R3", 2'd0, 0, 24'h010000, 1, 0, 1, 0);

    // R3: programmed code AA BB CC with a failing partial match, back-pressure
    stim = '{8'h10, 8'hAA, 8'hBB, 8'hAA, 8'hBB, 8'hCC, 8'h99};
    run_case("R3", 2'd0, 0, 24'hCCBBAA, 1, 0, 1, 1);

    // R4: count stop with held bytes flushed
    for (int k = 0; k < 12; k++) stim.push_back(8'h21 + 8'(k));
    run_case("R4", 2'd1, 10, 24'h010000, 1, 0, 1, 1);

    // R4: zero count
    stim = '{8'h01, 8'h02};
    run_case("R4", 2'd1, 0, 24'h010000, 1, 0, 1, 0);

    // R4: full-scale count
    for (int k = 0; k < 260; k++) stim.push_back(8'((k % 250) + 1));
    run_case("R4", 2'd1, 255, 24'h010000, 1, 0, 1, 1);

    // R2: code found before the count in mode 01
    stim = '{8'h44, 8'h00, 8'h00, 8'h01, 8'h45, 8'h46};
    run_case("R2", 2'd1, 6, 24'h010000, 1, 0, 1, 0);

    // R5: search bypassed, code passes through
    stim = '{8'h00, 8'h00, 8'h01, 8'h7E, 8'h00, 8'h01};
    run_case("R5", 2'd1, 6, 24'h010000, 0, 0, 1, 1);

    // R6: removal with saturating zero run
    stim = '{8'h00, 8'h00, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 8'h03, 8'h04};
    run_case("R6", 2'd1, 9, 24'h010000, 0, 1, 1, 0);

    // R6: zero count restarts after a removal
    stim = '{8'h00, 8'h00, 8'h03, 8'h00, 8'h03, 8'h05};
    run_case("R6", 2'd1, 6, 24'h010000, 0, 1, 1, 1);

    // R6: removal disabled keeps the 03
    stim = '{8'h00, 8'h00, 8'h03, 8'h00, 8'h03, 8'h05};
    run_case("R6", 2'd1, 6, 24'h010000, 0, 0, 1, 0);

    // R6: removal after the search stage
    stim = '{8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h01, 8'h09};
    run_case("R6", 2'd0, 0, 24'h010000, 1, 1, 1, 0);

    // R7: forwarding off
    stim = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36};
    run_case("R7", 2'd1, 5, 24'h010000, 1, 0, 0, 0);

    // R8: reserved modes
    stim = '{8'h01, 8'h02};
    run_case("R8", 2'd2, 4, 24'h010000, 1, 0, 1, 0);
    stim = '{8'h01, 8'h02};
    run_case("R8", 2'd3, 4, 24'h010000, 1, 0, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule